// File: doc/BRIEF.md
# Minimum-Pointer Survivor Shift Memory

This block is the survivor store of a hard-decision Viterbi decoder for a rate-1/2, four-state trellis. It receives one trellis step per handshake from the add-compare-select stage: one decision bit per state and the freshly computed path metric of every state. The block does not keep a full path history for each state. Instead, a pointer records which state currently has the smallest path metric. Only the decision bit of that state is pushed into one serial shift chain.

A decision bit of 1 means that the survivor into that state came along the lower branch. A decision bit of 0 means it came along the upper branch. The chain is `DEPTH` stages long, and `DEPTH` is derived from the constraint length. Each bit therefore leaves the chain as a decoded bit exactly `DEPTH` accepted steps after it entered. The output sits behind a one-entry valid/ready stage. The input side stalls whenever that stage holds a bit that has not been taken, so no decoded bit is ever dropped.

The pointer is brought out on a port, so the surrounding decoder can observe the best state. When no step is accepted, the pointer and the chain keep their contents and do not toggle.

Top module: `pbre_survivor_mem`

## Requirements
- R1: On every accepted step, `min_state` takes the index of the state whose `in_pm` field (state i occupies bits i*5 upward, 5-bit unsigned) is the smallest of that step. It is visible on the cycle after the accepting clock edge.
- R2: When several states share the smallest metric, `min_state` takes the lowest-numbered one among them.
- R3: The bit pushed into the chain is `in_dec[min_state]`, with 1 for lower branch and 0 for upper branch. `out_bit` presents these bits in step order, each `DEPTH` (default 4) accepted steps after the step that produced it.
- R4: `out_valid` stays low until `DEPTH` steps have been accepted. The first decoded bit appears with the (`DEPTH`+1)-th accepted step, and each accepted step after that produces one bit.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low. `out_bit`, `out_valid` and `min_state` then hold their values, whatever is driven on the input side.
- R6: A decoded bit taken with `out_ready` high, on a cycle with no accepted step, drops `out_valid` on the next cycle.
- R7: A synchronous reset sets `min_state` to 0, empties the chain and its fill count, and clears `out_valid`. After reset, `DEPTH` new steps are needed again before any output appears.
- R8: On a cycle with no accepted step, the pointer and the chain contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A trellis step is offered |
| in_ready | output | 1 | The block can accept a step this cycle |
| in_dec | input | 4 | Per-state decision bits (1 = lower branch) |
| in_pm | input | 20 | Per-state path metrics, 5 bits each, state 0 in the low bits |
| out_valid | output | 1 | `out_bit` holds a decoded bit |
| out_ready | input | 1 | Downstream takes the decoded bit |
| out_bit | output | 1 | Decoded bit |
| min_state | output | 2 | Index of the state holding the smallest path metric |

## Verification
The hardest situation to reach is a full chain with an untaken output bit while a new step waits at the input. In that state, the pointer, the chain and the output must all freeze, and then advance together by exactly one step on the cycle the stall releases. The stimulus first fills the chain from a vector table that also covers two-way, three-way and four-way metric ties. It then holds `out_ready` low for several cycles with a step offered whose minimum lies in a different state, and releases it for one cycle. It finishes with a mid-stream reset, followed by a refill, to show that the fill count restarts.

// File: rtl/smu_pkg.sv
package smu_pkg;
  // Comparison used by the minimum search: a candidate replaces the running
  // best only when strictly smaller, so ties keep the lower state index.
  localparam int CMP_W = 16;

  function automatic logic beats(input logic [CMP_W-1:0] cand,
                                 input logic [CMP_W-1:0] best);
    return cand < best;
  endfunction
endpackage

// File: rtl/smu_min_tracker.sv
module smu_min_tracker #(
  parameter int N_ST = 4,
  parameter int PM_W = 5,
  parameter int S_W  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_en,
  input  logic [N_ST*PM_W-1:0] pm_flat,
  input  logic [N_ST-1:0]      dec,
  output logic [S_W-1:0]       ptr_q,
  output logic                 sel_bit
);
  function automatic logic [PM_W-1:0] pm_of(input logic [N_ST*PM_W-1:0] v,
                                            input logic [S_W-1:0] idx);
    return v[idx*PM_W +: PM_W];
  endfunction

  logic [S_W-1:0]  run_idx [N_ST];
  logic [PM_W-1:0] run_val [N_ST];
  logic [S_W-1:0]  cand_idx;

  assign run_idx[0] = '0;
  assign run_val[0] = pm_flat[PM_W-1:0];

  for (genvar i = 1; i < N_ST; i++) begin : g_scan
    logic take;
    assign take = smu_pkg::beats(smu_pkg::CMP_W'(pm_flat[i*PM_W +: PM_W]),
                                 smu_pkg::CMP_W'(run_val[i-1]));
    assign run_idx[i] = take ? S_W'(i) : run_idx[i-1];
    assign run_val[i] = take ? pm_flat[i*PM_W +: PM_W] : run_val[i-1];
  end

  assign cand_idx = run_idx[N_ST-1];
  assign sel_bit  = dec[cand_idx];

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (step_en) ptr_q <= cand_idx;
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(ptr_q)); // R8

  for (genvar j = 0; j < N_ST; j++) begin : g_chk
    AST_PTR_IS_MIN: assert property (@(posedge clk) disable iff (rst)
      step_en |=> ((S_W'(j) < ptr_q)
        ? (pm_of($past(pm_flat), S_W'(j)) >  pm_of($past(pm_flat), ptr_q))
        : (pm_of($past(pm_flat), S_W'(j)) >= pm_of($past(pm_flat), ptr_q)))); // R1 R2
  end
endmodule

// File: rtl/smu_shift_chain.sv
module smu_shift_chain #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic din,
  output logic shift_out,
  output logic full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] chain_q;
  logic [CNT_W-1:0] fill_q;

  assign full      = (fill_q == CNT_W'(DEPTH));
  assign shift_out = chain_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      fill_q  <= '0;
    end else if (shift_en) begin
      chain_q <= {chain_q[DEPTH-2:0], din};
      if (!full) fill_q <= fill_q + 1'b1;
    end
  end

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain_q)); // R8

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CNT_W'(DEPTH)); // R4
endmodule

// File: rtl/smu_out_buf.sv
module smu_out_buf (
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic chain_full,
  input  logic shift_out,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (step_en && chain_full) begin
      out_valid <= 1'b1;
      out_bit   <= shift_out;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R5

  AST_OUT_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !step_en) |=> !out_valid); // R6
endmodule

// File: rtl/pbre_survivor_mem.sv
module pbre_survivor_mem #(
  parameter int CONSTR_LEN = 3,
  parameter int PM_W       = 5,
  parameter int N_ST       = 1 << (CONSTR_LEN - 1),
  parameter int S_W        = $clog2(N_ST),
  parameter int DEPTH      = 2 * (CONSTR_LEN - 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N_ST-1:0]      in_dec,
  input  logic [N_ST*PM_W-1:0] in_pm,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_bit,
  output logic [S_W-1:0]       min_state
);
  logic accept;
  logic sel_bit;
  logic shift_out;
  logic chain_full;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  smu_min_tracker #(.N_ST(N_ST), .PM_W(PM_W), .S_W(S_W)) u_track (
    .clk(clk), .rst(rst), .step_en(accept), .pm_flat(in_pm),
    .dec(in_dec), .ptr_q(min_state), .sel_bit(sel_bit)
  );

  smu_shift_chain #(.DEPTH(DEPTH)) u_chain (
    .clk(clk), .rst(rst), .shift_en(accept), .din(sel_bit),
    .shift_out(shift_out), .full(chain_full)
  );

  smu_out_buf u_out (
    .clk(clk), .rst(rst), .step_en(accept), .chain_full(chain_full),
    .shift_out(shift_out), .out_ready(out_ready),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> chain_full); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && min_state == '0)); // R7
endmodule

// File: tb/pbre_survivor_mem_tb.sv
module pbre_survivor_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int NV = 10;

  // {pm3, pm2, pm1, pm0, dec[3:0], expected pointer}
  localparam logic [25:0] VEC [NV] = '{
    {5'd9,  5'd4,  5'd7,  5'd12, 4'b0101, 2'd2},
    {5'd3,  5'd3,  5'd8,  5'd3,  4'b1000, 2'd0},
    {5'd0,  5'd5,  5'd5,  5'd6,  4'b1000, 2'd3},
    {5'd31, 5'd31, 5'd2,  5'd31, 4'b0010, 2'd1},
    {5'd10, 5'd11, 5'd12, 5'd10, 4'b0110, 2'd0},
    {5'd20, 5'd6,  5'd6,  5'd20, 4'b0100, 2'd1},
    {5'd0,  5'd0,  5'd0,  5'd0,  4'b1111, 2'd0},
    {5'd30, 5'd29, 5'd31, 5'd31, 4'b0100, 2'd2},
    {5'd1,  5'd31, 5'd31, 5'd31, 4'b0111, 2'd3},
    {5'd31, 5'd31, 5'd31, 5'd30, 4'b0001, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_dec = '0;
  logic [19:0] in_pm = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_bit;
  logic [1:0] min_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic bits [NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbre_survivor_mem u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dec(in_dec), .in_pm(in_pm), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .min_state(min_state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_vec(input int k);
    in_pm  = VEC[k][25:6];
    in_dec = VEC[k][5:2];
    in_valid = 1'b1;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NV; k++) bits[k] = VEC[k][2 + VEC[k][1:0]];
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R7: state after reset
    check("R7 out_valid after reset", out_valid, 0);
    check("R7 min_state after reset", min_state, 0);
    check("R7 in_ready after reset", in_ready, 1);

    // Table walk: R1 argmin, R2 ties (entries 1,4,5,6), R3 order, R4 fill
    for (int k = 0; k < NV; k++) begin
      drive_vec(k);
      tick();
      check((k == 1 || k == 4 || k == 5 || k == 6) ? "R2 tie pointer" : "R1 pointer",
            min_state, VEC[k][1:0]);
      check("R4 out_valid fill", out_valid, (k >= DEPTH) ? 1 : 0);
      if (k >= DEPTH) check("R3 decoded bit", out_bit, bits[k - DEPTH]);
    end

    // R5 stall: output held, input blocked
    out_ready = 1'b0;
    in_pm  = {5'd0, 5'd9, 5'd9, 5'd9};
    in_dec = 4'b1000;
    #1;
    check("R5 in_ready low in stall", in_ready, 0);
    for (int c = 0; c < 3; c++) begin
      tick();
      check("R5 out_valid held", out_valid, 1);
      check("R5 out_bit held", out_bit, bits[5]);
      check("R8 pointer held in stall", min_state, 0);
    end
    out_ready = 1'b1;
    tick();
    check("R1 pointer after release", min_state, 3);
    check("R3 next bit after release", out_bit, bits[6]);
    check("R4 valid after release", out_valid, 1);
    in_valid = 1'b0;
    tick();
    check("R6 out_valid drops", out_valid, 0);
    check("R8 pointer held idle", min_state, 3);
    tick();
    check("R6 out_valid stays low", out_valid, 0);

    // R7 mid-stream reset then refill
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    check("R7 out_valid after mid reset", out_valid, 0);
    check("R7 min_state after mid reset", min_state, 0);
    for (int k = 0; k <= DEPTH; k++) begin
      drive_vec(k);
      tick();
      check("R7 refill valid", out_valid, (k >= DEPTH) ? 1 : 0);
      check("R1 pointer on refill", min_state, VEC[k][1:0]);
    end
    check("R7 first bit after refill", out_bit, bits[0]);
    in_valid = 1'b0;
    tick();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule